// File: doc/BRIEF.md
# Coincident-Edge Sync Pulse Generator

This block runs on a fast clock and tracks two slower clocks, bank A and bank C, each obtained from the fast clock by its own even divide ratio. It drives a single active-low marker, `sync_n`, that drops ahead of every instant where both bank clocks rise on the same fast-clock cycle. The low time and position of the marker follow whichever bank is faster. The marker falls on a rising edge of the faster bank and returns high on the shared rising edge. This holds for any pair of ratios, whether or not one ratio divides the other.

The block holds one phase counter per bank, and these counters mirror the bank dividers. After reset both counters sit at phase zero, so the two banks begin with a shared rising edge. Each bank has a 3-bit ratio code. A new code takes effect only on a cycle where both banks are at phase zero, so shared edges continue to occur after a change. While a code change is waiting, no new marker begins. A marker that has already started always runs to its end. All pins are plain control and status levels, so no valid/ready handshake applies.

Top module: `sync_coinc_gen`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `sync_n` is 1.
- R2: A bank's divide ratio is 2*(code+1) fast cycles, so codes 0..7 give ratios 2..16. In the first cycle after reset (cycle 0), both banks are at their rising edge.
- R3: With unequal ratios, each low interval of `sync_n` lasts exactly min(ratio A, ratio C) fast cycles.
- R4: With unequal ratios, `sync_n` returns to 1 in the cycle where both banks rise together.
- R5: With unequal ratios, `sync_n` falls exactly min(ratio A, ratio C) cycles before a shared rising edge, on a rising edge of the faster bank.
- R6: With unequal ratios, exactly one low interval occurs per common period lcm(ratio A, ratio C). Counting from cycle 0, `sync_n` is low at cycle t exactly when (t mod lcm) >= lcm - min.
- R7: With equal ratios R, `sync_n` is 1 for cycles 1..R-1 and stays 0 from cycle R onward.
- R8: A changed code takes effect only at the next cycle where both banks rise together, and the new ratios count from there. While the change waits, no low interval begins.
- R9: A low interval that has already begun when a code changes runs to its full length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock from which both banks are divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| code_a | input | CODE_W | Bank A ratio code, ratio = 2*(code+1) |
| code_c | input | CODE_W | Bank C ratio code, ratio = 2*(code+1) |
| sync_n | output | 1 | Active-low coincidence marker, registered |

## Verification
The assertions assume that reset is held low at the first clock edge and that the code inputs settle away from the rising clock edge. They place no other limit on when codes may change. The stimulus meets these assumptions. Reset is applied at time zero and before every configuration. The codes are driven only on falling edges, and each run-time change happens at a chosen cycle relative to the first shared edge. This lets the bench compute the expected waveform from the lcm/min formula, split into the periods before and after the change.

// File: rtl/sync_coinc_pkg.sv
package sync_coinc_pkg;

  // Ratio code to divide ratio in fast-clock cycles (always even, >= 2).
  function automatic int unsigned code_to_ratio(int unsigned code);
    return 2 * (code + 1);
  endfunction

endpackage

// File: rtl/bank_phase.sv
module bank_phase
  import sync_coinc_pkg::*;
#(
  parameter int CODE_W = 3,
  parameter int RAT_W  = CODE_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code,
  input  logic              load,
  output logic              at_zero,
  output logic              differs,
  output logic [RAT_W-1:0]  ratio,
  output logic [RAT_W-1:0]  nxt_cnt,
  output logic [RAT_W-1:0]  nxt_ratio
);

  logic [RAT_W-1:0] cnt_q;
  logic [RAT_W-1:0] ratio_q;
  logic [RAT_W-1:0] ratio_req;

  assign ratio_req = RAT_W'(code_to_ratio(int'(code)));
  assign differs   = (ratio_req != ratio_q);
  assign at_zero   = (cnt_q == '0);
  assign ratio     = ratio_q;

  // A new ratio is adopted only when told; the phase restarts its count
  // from the shared edge, so the next phase is 1 under either ratio.
  assign nxt_ratio = load ? ratio_req : ratio_q;
  assign nxt_cnt   = (cnt_q == ratio_q - RAT_W'(1)) ? '0 : cnt_q + RAT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ratio_q <= RAT_W'(2);
    end else begin
      cnt_q   <= nxt_cnt;
      ratio_q <= nxt_ratio;
    end
  end

  // Phase always stays inside the active ratio (R2).
  p_phase_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < ratio_q);

endmodule

// File: rtl/coinc_window.sv
module coinc_window #(
  parameter int RAT_W = 5
) (
  input  logic [RAT_W-1:0] ratio_a,
  input  logic [RAT_W-1:0] cnt_a,
  input  logic [RAT_W-1:0] ratio_c,
  input  logic [RAT_W-1:0] cnt_c,
  output logic             coinc_ahead,
  output logic             fast_edge
);

  logic [RAT_W-1:0] left_a;
  logic [RAT_W-1:0] left_c;

  // Cycles until each bank's next rising edge, strictly in the future.
  assign left_a = ratio_a - cnt_a;
  assign left_c = ratio_c - cnt_c;

  // Both next edges fall on the same cycle: within one faster period of a
  // shared edge.
  assign coinc_ahead = (left_a == left_c);

  // Rising edge of the faster bank (A when equal).
  assign fast_edge = (ratio_a <= ratio_c) ? (cnt_a == '0) : (cnt_c == '0);

endmodule

// File: rtl/sync_coinc_gen.sv
module sync_coinc_gen #(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code_a,
  input  logic [CODE_W-1:0] code_c,
  output logic              sync_n
);

  localparam int RAT_W = CODE_W + 2;
  localparam int NB    = 2;
  localparam int BA    = 0;
  localparam int BC    = 1;

  logic [CODE_W-1:0] code_v  [NB];
  logic [RAT_W-1:0]  ratio_v [NB];
  logic [RAT_W-1:0]  ncnt_v  [NB];
  logic [RAT_W-1:0]  nrat_v  [NB];
  logic [NB-1:0]     zero_v;
  logic [NB-1:0]     diff_v;

  logic common, pending, load;
  logic win_n, start_n, low_d, sync_n_q;

  assign code_v[BA] = code_a;
  assign code_v[BC] = code_c;

  assign common  = &zero_v;
  assign pending = |diff_v;
  assign load    = common & pending;

  for (genvar g = 0; g < NB; g++) begin : g_bank
    bank_phase #(
      .CODE_W (CODE_W),
      .RAT_W  (RAT_W)
    ) i_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .code      (code_v[g]),
      .load      (load),
      .at_zero   (zero_v[g]),
      .differs   (diff_v[g]),
      .ratio     (ratio_v[g]),
      .nxt_cnt   (ncnt_v[g]),
      .nxt_ratio (nrat_v[g])
    );
  end

  // Evaluate the state the banks move to, so the marker register lines up
  // with the phase registers.
  coinc_window #(
    .RAT_W (RAT_W)
  ) i_win (
    .ratio_a     (nrat_v[BA]),
    .cnt_a       (ncnt_v[BA]),
    .ratio_c     (nrat_v[BC]),
    .cnt_c       (ncnt_v[BC]),
    .coinc_ahead (win_n),
    .fast_edge   (start_n)
  );

  // A marker begins only on a faster-bank edge with no change waiting;
  // once begun it holds while the shared edge is still ahead.
  assign low_d = win_n && (!sync_n_q || (start_n && !pending));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_n_q <= 1'b1;
    else        sync_n_q <= !low_d;
  end

  assign sync_n = sync_n_q;

  // ---------------------------------------------------------------------
  // Checks on marker timing
  // ---------------------------------------------------------------------
  logic [RAT_W-1:0] run_q;
  logic [RAT_W-1:0] fmin;
  logic             fast_zero;

  assign fmin      = (ratio_v[BA] <= ratio_v[BC]) ? ratio_v[BA] : ratio_v[BC];
  assign fast_zero = (ratio_v[BA] <= ratio_v[BC]) ? zero_v[BA] : zero_v[BC];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 run_q <= '0;
    else if (sync_n_q)          run_q <= '0;
    else if (run_q != '1)       run_q <= run_q + RAT_W'(1);
  end

  p_pulse_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_n_q && (ratio_v[BA] != ratio_v[BC])) |-> (run_q < fmin));

  p_rise_at_common_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_n_q) |-> (common || $past(ratio_v[BA] == ratio_v[BC])));

  p_fall_on_fast_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync_n_q) |-> fast_zero);

  p_ratio_at_common_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(ratio_v[BA]) || !$stable(ratio_v[BC])) |-> $past(common));

endmodule

// File: tb/test_sync_coinc_gen.sv
module test_sync_coinc_gen;

  localparam int CW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] code_a = '0;
  logic [CW-1:0] code_c = '0;
  logic          sync_n;

  int nvec = 0;
  int nfail = 0;

  always #5 clk = ~clk;

  sync_coinc_gen #(.CODE_W(CW)) i_sync_coinc_gen (
    .clk    (clk),
    .rst_n  (rst_n),
    .code_a (code_a),
    .code_c (code_c),
    .sync_n (sync_n)
  );

  function automatic int ratio_of(int c);
    return 2 * (c + 1);
  endfunction

  function automatic int gcd(int a, int b);
    int x = a;
    int y = b;
    while (y != 0) begin
      int t = y;
      y = x % y;
      x = t;
    end
    return x;
  endfunction

  function automatic int lcm(int a, int b);
    return (a / gcd(a, b)) * b;
  endfunction

  function automatic int imin(int a, int b);
    return (a < b) ? a : b;
  endfunction

  // Expected low level at cycle t counted from the first post-reset cycle.
  function automatic bit exp_low(int ra, int rc, int t);
    int l = lcm(ra, rc);
    int f = imin(ra, rc);
    if (ra == rc) return (t >= ra);
    if (t == 0) return 1'b0;
    return (t % l) >= (l - f);
  endfunction

  task automatic check(bit low, string tag, int t);
    nvec++;
    if (sync_n !== !low) begin
      nfail++;
      $display("FAIL %s cycle %0d: sync_n=%b expected %b", tag, t, sync_n, !low);
    end
  endtask

  task automatic do_reset(int a, int c);
    @(negedge clk);
    rst_n  = 1'b0;
    code_a = CW'(a);
    code_c = CW'(c);
    repeat (2) @(negedge clk);
    check(1'b0, "R1 (in reset)", -1);
    rst_n = 1'b1;
    #1;
    check(1'b0, "R1 (cycle 0)", 0);
  endtask

  // Sweep of every code pair against the lcm/min formula.
  task automatic sweep();
    for (int a = 0; a < (1 << CW); a++) begin
      for (int c = 0; c < (1 << CW); c++) begin
        int ra = ratio_of(a);
        int rc = ratio_of(c);
        int l  = lcm(ra, rc);
        int f  = imin(ra, rc);
        int n  = (ra == rc) ? 3 * ra + 2 : 3 * l;
        do_reset(a, c);
        for (int t = 1; t <= n; t++) begin
          string tag;
          @(negedge clk);
          if (ra == rc)                 tag = "R7";
          else if (t % l == 0)          tag = "R4";
          else if (t % l == l - f)      tag = "R5";
          else if (t % l > l - f)       tag = "R3";
          else                          tag = "R2,R6";
          check(exp_low(ra, rc, t), tag, t);
        end
      end
    end
  endtask

  // Codes (1,2) -> ratios 4,6 (lcm 12, window 8..11); at cycle tchg
  // code_a becomes 0 (ratio 2), adopted at the shared edge of cycle 12.
  task automatic change_run(int tchg, string tag);
    int l = 12;
    int w = 8;
    do_reset(1, 2);
    for (int t = 1; t <= 40; t++) begin
      bit low;
      @(negedge clk);
      if (t <= tchg)       low = exp_low(4, 6, t);
      else if (t < l)      low = (t >= w) && (tchg >= w);
      else                 low = exp_low(2, 6, t - l);
      check(low, tag, t);
      if (t == tchg) code_a = CW'(0);
    end
  endtask

  initial begin
    sweep();
    change_run(2, "R8");
    change_run(9, "R9");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule